// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A table of 2-bit saturating confidence counters is indexed by the word-address bits of the branch PC combined by exclusive-OR with a register of recent global branch outcomes. Two branches at different addresses with the same recent history land on different counters. One branch reached along different paths also lands on different counters. As a result, correlation between neighbouring branches is learned as well as each branch's own bias.

The fetch stage presents a PC on the lookup port. The direction and the table index it used come back combinationally in the same cycle. The fetch stage carries that index down the pipe with the branch. When the branch resolves, the back end returns the carried index and the real outcome on the update port. That counter then moves one step toward the outcome, and the outcome enters the global history. Because the stored index is used, training stays correct after the history has moved on. No lookup can be stalled, so the lookup side has a valid but no ready: `lk_pred_valid` follows `lk_valid` in the same cycle. On the update side `upd_ready` is high whenever reset is low. An update beat is taken in any cycle where `upd_valid` and `upd_ready` are both high, and the block never applies back-pressure.

Top module: `gshare_predictor`

## Requirements
- R1: After reset, every counter holds weak not-taken (code 1) and the global history is all zeros. A lookup then predicts not-taken and reports index `lk_pc[13:2]`.
- R2: The lookup index is `lk_pc[13:2]` XOR the 12-bit global history. PC bits 1:0 and bits above 13 have no effect.
- R3: Counter codes are 0 strong not-taken, 1 weak not-taken, 2 weak taken and 3 strong taken. `lk_taken` is 1 exactly when the indexed counter holds code 2 or 3.
- R4: An accepted update moves counter `upd_idx` one step up when `upd_taken` is 1 and one step down when it is 0.
- R5: A counter at code 3 stays at 3 on a taken update, and a counter at code 0 stays at 0 on a not-taken update.
- R6: An accepted update shifts `upd_taken` into history bit 0 (1 for taken) and drops bit 11.
- R7: Training touches only the counter named by `upd_idx`, whatever the current history is.
- R8: A lookup answers in the same cycle. An update takes effect from the next clock edge, so a lookup in the same cycle as an update sees the values from before the update.
- R9: `upd_ready` is 1 whenever reset is low. In a cycle with `upd_valid` low, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_pc | input | 32 | PC of the branch being fetched |
| lk_pred_valid | output | 1 | Prediction valid (same cycle as request) |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_idx | output | 12 | Table index used for this prediction |
| upd_valid | input | 1 | Resolved-branch update valid |
| upd_ready | output | 1 | Update accepted (high outside reset) |
| upd_idx | input | 12 | Index captured at lookup time |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench is tested with a single taken update from reset. This separates a start at weak not-taken from a start anywhere else, because one taken outcome must flip the prediction. Long runs of taken or of not-taken outcomes followed by one opposite outcome separate true saturation from wrap-around. More than twelve mixed outcomes are read back through `lk_idx` with a zero PC, which shows shift order and loss of the oldest bit. An update to an index unrelated to the current history checks R7. A lookup and an update aimed at one entry in the same cycle check R8. Idle cycles check that nothing drifts when no update is offered.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // one saturating step toward the resolved direction
  function automatic ctr_e ctr_step(ctr_e cur, logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken && cur != CTR_ST)
      nxt = ctr_e'(cur + 2'd1);
    else if (!taken && cur != CTR_SNT)
      nxt = ctr_e'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gshare_hash.sv
module gshare_hash #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 12,
  parameter int HIST_W = 12
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  localparam int PC_LSB = 2;
  localparam int PC_MSB = IDX_W + PC_LSB - 1;

  logic [IDX_W-1:0] hist_ext;
  logic             unused_pc_bits;

  generate
    if (HIST_W == IDX_W) begin : g_hist_full
      assign hist_ext = hist;
    end else if (HIST_W < IDX_W) begin : g_hist_pad
      assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist};
    end else begin : g_hist_bad
      $error("gshare_hash: HIST_W must not exceed IDX_W");
      assign hist_ext = '0;
    end

    if (PC_W > PC_MSB + 1) begin : g_pc_hi
      assign unused_pc_bits = ^{pc[PC_W-1:PC_MSB+1], pc[PC_LSB-1:0]};
    end else begin : g_pc_exact
      assign unused_pc_bits = ^pc[PC_LSB-1:0];
    end
  endgenerate

  assign idx = pc[PC_MSB:PC_LSB] ^ hist_ext;

endmodule

// File: rtl/gshare_ghr.sv
module gshare_ghr #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= outcome;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], outcome};
      end
    end
  endgenerate

  // R6: newest outcome lands in bit 0, older bits move up by one
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist[0] == $past(outcome)) &&
                 ((hist >> 1) == ($past(hist) & {1'b0, {(HIST_W-1){1'b1}}})));

  // R9: no accepted update, no history movement
  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist));

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_e             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_e tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_WNT;
    end else if (wr_en) begin
      tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
    end
  end

  // read reflects state before any same-cycle write (R8)
  assign rd_ctr = tbl[rd_idx];

  // R4: taken training raises a non-saturated counter by one
  assert_ctr_up_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && tbl[wr_idx] != CTR_ST) |=>
      (tbl[$past(wr_idx)] == ctr_e'($past(tbl[wr_idx]) + 2'd1)));

  // R4: not-taken training lowers a non-saturated counter by one
  assert_ctr_down_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && tbl[wr_idx] != CTR_SNT) |=>
      (tbl[$past(wr_idx)] == ctr_e'($past(tbl[wr_idx]) - 2'd1)));

  // R5: saturation at the top end
  assert_ctr_sat_hi_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && tbl[wr_idx] == CTR_ST) |=>
      (tbl[$past(wr_idx)] == CTR_ST));

  // R5: saturation at the bottom end
  assert_ctr_sat_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && tbl[wr_idx] == CTR_SNT) |=>
      (tbl[$past(wr_idx)] == CTR_SNT));

  // R9: the entry being read does not move without a write
  assert_ctr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (tbl[$past(rd_idx)] == $past(rd_ctr)));

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 12,
  parameter int HIST_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_pred_valid,
  output logic             lk_taken,
  output logic [IDX_W-1:0] lk_idx,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);

  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  look_idx;
  ctr_e              look_ctr;
  logic              upd_fire;

  assign upd_ready = ~rst;
  assign upd_fire  = upd_valid & upd_ready;

  gshare_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash (
    .pc   (lk_pc),
    .hist (ghist),
    .idx  (look_idx)
  );

  gshare_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_fire),
    .outcome  (upd_taken),
    .hist     (ghist)
  );

  gshare_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (look_idx),
    .rd_ctr   (look_ctr),
    .wr_en    (upd_fire),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );

  assign lk_pred_valid = lk_valid;
  assign lk_idx        = look_idx;
  assign lk_taken      = ctr_says_taken(look_ctr);

endmodule

// File: tb/gshare_predictor_tb.sv
module gshare_predictor_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [31:0] lk_pc;
  logic        lk_pred_valid;
  logic        lk_taken;
  logic [11:0] lk_idx;
  logic        upd_valid;
  logic        upd_ready;
  logic [11:0] upd_idx;
  logic        upd_taken;

  always #5 clk = ~clk;

  gshare_predictor u_dut (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .lk_pc         (lk_pc),
    .lk_pred_valid (lk_pred_valid),
    .lk_taken      (lk_taken),
    .lk_idx        (lk_idx),
    .upd_valid     (upd_valid),
    .upd_ready     (upd_ready),
    .upd_idx       (upd_idx),
    .upd_taken     (upd_taken)
  );

  int tests = 0;
  int fails = 0;
  int model_ctr [4096];
  int model_hist;
  bit done = 1'b0;

  int    q_idx [$];
  bit    q_tk  [$];
  string q_tag [$];

  // driver: one call = one cycle of stimulus, expectations pushed to scoreboard
  task automatic cycle(input bit lk, input int pc, input bit up,
                       input int idx, input bit tk, input string tag);
    int e_idx;
    @(negedge clk);
    lk_valid  = lk;
    lk_pc     = pc;
    upd_valid = up;
    upd_idx   = idx[11:0];
    upd_taken = tk;
    if (lk) begin
      e_idx = ((pc >> 2) & 4095) ^ model_hist;
      q_idx.push_back(e_idx);
      q_tk.push_back(model_ctr[e_idx] >= 2);
      q_tag.push_back(tag);
    end
    if (up) begin
      if (tk && model_ctr[idx] < 3) model_ctr[idx]++;
      if (!tk && model_ctr[idx] > 0) model_ctr[idx]--;
      model_hist = ((model_hist << 1) | int'(tk)) & 4095;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, "idle");
  endtask

  // monitor: samples 2 ns after the driving edge, well before the next rise
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && upd_valid) begin
        tests++;
        if (upd_ready !== 1'b1) begin
          fails++;
          $display("FAIL R9 upd_ready actual=%b expected=1", upd_ready);
        end
      end
      if (!rst && lk_valid) begin
        int    e_idx;
        bit    e_tk;
        string tg;
        e_idx = q_idx.pop_front();
        e_tk  = q_tk.pop_front();
        tg    = q_tag.pop_front();
        tests++;
        if (lk_pred_valid !== 1'b1 || int'(lk_idx) != e_idx || lk_taken !== e_tk) begin
          fails++;
          $display("FAIL %s vld=%b idx=%0d taken=%b expected vld=1 idx=%0d taken=%b",
                   tg, lk_pred_valid, lk_idx, lk_taken, e_idx, e_tk);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) model_ctr[i] = 1;
    model_hist = 0;
    rst = 1'b1; lk_valid = 1'b0; lk_pc = '0;
    upd_valid = 1'b0; upd_idx = '0; upd_taken = 1'b0;
    repeat (3) @(negedge clk);
    tests++;
    if (upd_ready !== 1'b0) begin
      fails++;
      $display("FAIL R9 upd_ready in reset actual=%b expected=0", upd_ready);
    end
    rst = 1'b0;

    // R1 reset state, R2 PC bit selection
    cycle(1, 32'h0000_0000, 0, 0, 0, "R1 reset zero pc");
    cycle(1, 32'hFFFF_ABC3, 0, 0, 0, "R1 R2 reset high pc");
    cycle(1, 32'h0000_0003, 0, 0, 0, "R2 low pc bits ignored");

    // R4 one taken from weak not-taken flips prediction; R7 index from port
    cycle(0, 0, 1, 5, 1, "upd");
    cycle(1, 32'h10, 0, 0, 0, "R4 R7 one taken flips idx5");
    cycle(1, 32'h14, 0, 0, 0, "R3 R7 neighbour idx untouched");

    // R5 top saturation: 5 taken then 1 not-taken still predicts taken
    for (int i = 0; i < 5; i++) cycle(0, 0, 1, 7, 1, "upd");
    cycle(0, 0, 1, 7, 0, "upd");
    cycle(1, (7 ^ model_hist) << 2, 0, 0, 0, "R5 saturate high");

    // R5 bottom saturation: 4 not-taken then 1 taken still predicts not-taken
    for (int i = 0; i < 4; i++) cycle(0, 0, 1, 9, 0, "upd");
    cycle(0, 0, 1, 9, 1, "upd");
    cycle(1, (9 ^ model_hist) << 2, 0, 0, 0, "R5 saturate low");

    // R6 history: >12 mixed outcomes to idx 100, read history via zero pc
    for (int i = 0; i < 15; i++) cycle(0, 0, 1, 100, (i % 3) == 0, "upd");
    cycle(1, 0, 0, 0, 0, "R6 history after 15 shifts");
    cycle(1, 32'h0000_3FFC, 0, 0, 0, "R2 xor with full history");

    // R9 idle cycles: nothing drifts
    idle(4);
    cycle(1, 0, 0, 0, 0, "R9 history stable when idle");
    cycle(1, (7 ^ model_hist) << 2, 0, 0, 0, "R9 counter stable when idle");

    // R8 same-cycle lookup and update to one entry: old value seen
    cycle(1, (300 ^ model_hist) << 2, 1, 300, 1, "R8 read before write");
    cycle(1, (300 ^ model_hist) << 2, 0, 0, 0, "R8 write visible next cycle");

    // R7 training with stale index while history differs
    cycle(0, 0, 1, 2000, 1, "upd");
    cycle(0, 0, 1, 2000, 1, "upd");
    cycle(1, (2000 ^ model_hist) << 2, 0, 0, 0, "R7 stale index trains its entry");
    cycle(1, (2001 ^ model_hist) << 2, 0, 0, 0, "R7 other entry untouched");

    idle(2);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule